// File: doc/BRIEF.md
# Tape Controller Host Register File

This block is the register file a host sees when it talks to a magnetic tape controller over a simple 16-bit bus with byte writes. It holds the command word, the transfer byte count and memory address, an 8-bit data buffer and a free-running "read lines" word. It also builds a live status word from the controller's own error flags and from the dynamic status lines of the tape unit that the command selects.

The block enforces the command-register write rules. A command write is refused while a function is in progress, and a write with the initialise bit set resets the controller. The block keeps track of done, error and interrupt requests, and it hands each new function to the transfer sequencer as a one-cycle start pulse that carries the function and unit numbers. When the sequencer finishes, it returns a finish pulse with its error flags.

Top module: `tape_regfile`

## Requirements
- R1: After reset the command register reads 0x0080 (only DONE, bit 7, set). Byte count, memory address, data buffer and read-lines read 0, no interrupt is requested, and no start pulse is given.
- R2: Register select is byte address bits 3:1: 0 status, 1 command, 2 byte count, 3 memory address, 4 data buffer, 5 read-lines. Offsets 6 and 7 read as 0. A write to the status register has no effect.
- R3: For the byte count, memory address and command registers, a word write replaces all 16 bits. A byte write takes its data from wdata[7:0]: at an odd address it replaces bits 15:8, and at an even address it replaces bits 7:0.
- R4: The data buffer stores only 8 bits and reads 0 in bits 15:8. A byte write to its odd address changes nothing.
- R5: Command bit layout: 0 GO, 3:1 function, 5:4 extended address, 6 interrupt enable (IE), 7 DONE, 10:8 unit, 11 parity select, 12 INIT, 14:13 density, 15 ERR. Only the density, parity, unit, IE, extended-address and function fields are stored from a write (mask 0x6F7E). GO, INIT, DONE and ERR written by the host are not stored.
- R6: A command write while DONE is 0 leaves the command register unchanged and sets the illegal flag (status bit 15).
- R7: An accepted command write with INIT (bit 12) set clears every register and error flag, sets DONE and drops the interrupt request.
- R8: An accepted command write with IE=0 drops the interrupt request. One with IE=1 while the stored IE is 0 and DONE or ERR is set raises it. The interrupt request is never active while IE is 0.
- R9: An accepted command write with GO=1 (and no INIT) clears DONE, the stored error flags and the interrupt request. On the next cycle it gives a one-cycle start pulse whose function and unit outputs equal the newly written fields.
- R10: A finish pulse while DONE is 0 sets DONE and ORs in its error flags (fin_err_i bit 0 CRC, 1 parity, 2 data late, 3 record length, 4 bad tape, 5 non-existent memory; fin_ill_i sets illegal). If IE is set, it also raises the interrupt request.
- R11: Status bits 15..0 are: illegal, end of file, CRC, parity, data late, end of tape, record length, bad tape, non-existent memory, online, load point, 0, 0, write locked, rewinding, ready. The end of file, end of tape, online, load point, write locked and rewinding bits come from the selected unit. Ready is the inverse of that unit's busy line. Each unit's 7-bit status slice is: 0 EOF, 1 EOT, 2 online, 3 load point, 4 write locked, 5 rewinding, 6 busy.
- R12: Command bit 15 (ERR) is 1 exactly when any of status bits 15..7 is set.
- R13: Each read of the read-lines register toggles its bit 15 and returns the toggled value. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_byte_i | input | 1 | Byte access |
| bus_addr_i | input | 4 | Byte address within the register window |
| bus_wdata_i | input | 16 | Write data (byte data on bits 7:0) |
| bus_rdata_o | output | 16 | Read data, combinational in the access cycle |
| unit_stat_i | input | NUM_UNITS*7 | Dynamic status slices of all units |
| fin_i | input | 1 | Sequencer finished the function |
| fin_err_i | input | 6 | Error flags reported with the finish |
| fin_ill_i | input | 1 | Sequencer rejected the function as illegal |
| start_o | output | 1 | One-cycle start of a new function |
| start_func_o | output | 3 | Function code for the sequencer |
| start_unit_o | output | 3 | Unit number for the sequencer |
| xfer_addr_o | output | 18 | Extended address and memory address |
| xfer_count_o | output | 16 | Byte count register |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples it inside the access cycle, before the edge that commits any read side effect such as the read-lines toggle. Register writes, DONE, ERR, the interrupt request and the stored error flags all take effect at the edge that ends the access, so the bench checks them on the falling edge after that edge. The start pulse is registered once, so it is high during the cycle right after the accepted write. The bench checks it there and then again one rising edge later, when it must be low. Status bits taken from the unit lines need no edge, and the bench reads them back after changing the lines.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;

  localparam int DW     = 16;
  localparam int UNIT_W = 3;
  localparam int US_W   = 7;
  localparam int FE_W   = 6;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_ADDR  = 3'd3,
    SEL_DBUF  = 3'd4,
    SEL_LINES = 3'd5
  } reg_sel_e;

  // command word bit positions
  localparam int C_GO   = 0;
  localparam int C_FN   = 1;
  localparam int C_EA   = 4;
  localparam int C_IE   = 6;
  localparam int C_DONE = 7;
  localparam int C_UNIT = 8;
  localparam int C_INIT = 12;
  localparam int C_ERR  = 15;
  localparam logic [DW-1:0] CMD_RW_MASK = 16'h6F7E;

  // status word bit positions
  localparam int S_ILL = 15;
  localparam int S_EOF = 14;
  localparam int S_CRC = 13;
  localparam int S_PAR = 12;
  localparam int S_DLT = 11;
  localparam int S_EOT = 10;
  localparam int S_RLE = 9;
  localparam int S_BAD = 8;
  localparam int S_NXM = 7;
  localparam int S_ONL = 6;
  localparam int S_BOT = 5;
  localparam int S_WLK = 2;
  localparam int S_REW = 1;
  localparam int S_TUR = 0;
  localparam logic [DW-1:0] ERR_FLAG_MASK = 16'hFF80;

  // per-unit status slice positions
  localparam int U_EOF  = 0;
  localparam int U_EOT  = 1;
  localparam int U_ONL  = 2;
  localparam int U_BOT  = 3;
  localparam int U_WLK  = 4;
  localparam int U_REW  = 5;
  localparam int U_BUSY = 6;

  // finish error positions
  localparam int F_CRC = 0;
  localparam int F_PAR = 1;
  localparam int F_DLT = 2;
  localparam int F_RLE = 3;
  localparam int F_BAD = 4;
  localparam int F_NXM = 5;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic          is_byte,
                                               input logic          odd);
    logic [DW-1:0] r;
    if (!is_byte)  r = new_v;
    else if (odd)  r = {new_v[7:0], old_v[7:0]};
    else           r = {old_v[DW-1:8], new_v[7:0]};
    return r;
  endfunction

endpackage

// File: rtl/tape_cmd_reg.sv
module tape_cmd_reg
  import tape_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          err_i,
  input  logic          fin_i,
  output logic [DW-1:0] cmd_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          start_o,
  output logic          init_o,
  output logic          go_o,
  output logic          refuse_o
);

  logic [DW-1:0] cmd_q, cmd_d;
  logic          done_q, done_d;
  logic          irq_q, irq_d;
  logic          start_q, start_d;
  logic          accept, reg_en;

  assign accept   = wr_i & done_q;
  assign init_o   = accept & wdata_i[C_INIT];
  assign go_o     = accept & ~wdata_i[C_INIT] & wdata_i[C_GO];
  assign refuse_o = wr_i & ~done_q;
  assign reg_en   = accept | fin_i | start_q;

  always_comb begin
    cmd_d   = cmd_q;
    done_d  = done_q;
    irq_d   = irq_q;
    start_d = 1'b0;
    if (init_o) begin
      cmd_d  = '0;
      done_d = 1'b1;
      irq_d  = 1'b0;
    end else if (accept) begin
      cmd_d = wdata_i & CMD_RW_MASK;
      if (!wdata_i[C_IE])
        irq_d = 1'b0;
      else if ((done_q | err_i) && !cmd_q[C_IE])
        irq_d = 1'b1;
      if (go_o) begin
        done_d  = 1'b0;
        irq_d   = 1'b0;
        start_d = 1'b1;
      end
    end else if (fin_i && !done_q) begin
      done_d = 1'b1;
      if (cmd_q[C_IE]) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      done_q  <= 1'b1;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else if (reg_en) begin
      cmd_q   <= cmd_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      start_q <= start_d;
    end
  end

  assign cmd_o   = cmd_q;
  assign done_o  = done_q;
  assign irq_o   = irq_q;
  assign start_o = start_q;

endmodule

// File: rtl/tape_status.sv
module tape_status
  import tape_regs_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   set_ill_i,
  input  logic                   fin_i,
  input  logic [FE_W-1:0]        fin_err_i,
  input  logic [UNIT_W-1:0]      unit_sel_i,
  input  logic [NUM_UNITS*US_W-1:0] unit_stat_i,
  output logic [DW-1:0]          stat_o,
  output logic                   err_o
);

  localparam int SLOTS = 1 << UNIT_W;

  logic [US_W-1:0] slot_a [SLOTS];
  logic [US_W-1:0] cur;
  logic            ill_q, ill_d;
  logic [FE_W-1:0] fe_q, fe_d;
  logic            upd_en;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_UNITS) begin : g_present
      assign slot_a[g] = unit_stat_i[g*US_W +: US_W];
    end else begin : g_absent
      assign slot_a[g] = '0;
    end
  end

  assign cur    = slot_a[unit_sel_i];
  assign upd_en = clr_i | set_ill_i | fin_i;

  always_comb begin
    ill_d = clr_i ? 1'b0 : ill_q;
    fe_d  = clr_i ? '0   : fe_q;
    if (set_ill_i) ill_d = 1'b1;
    if (fin_i)     fe_d  = fe_d | fin_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q <= 1'b0;
      fe_q  <= '0;
    end else if (upd_en) begin
      ill_q <= ill_d;
      fe_q  <= fe_d;
    end
  end

  always_comb begin
    stat_o        = '0;
    stat_o[S_ILL] = ill_q;
    stat_o[S_EOF] = cur[U_EOF];
    stat_o[S_CRC] = fe_q[F_CRC];
    stat_o[S_PAR] = fe_q[F_PAR];
    stat_o[S_DLT] = fe_q[F_DLT];
    stat_o[S_EOT] = cur[U_EOT];
    stat_o[S_RLE] = fe_q[F_RLE];
    stat_o[S_BAD] = fe_q[F_BAD];
    stat_o[S_NXM] = fe_q[F_NXM];
    stat_o[S_ONL] = cur[U_ONL];
    stat_o[S_BOT] = cur[U_BOT];
    stat_o[S_WLK] = cur[U_WLK];
    stat_o[S_REW] = cur[U_REW];
    stat_o[S_TUR] = ~cur[U_BUSY];
  end

  assign err_o = |(stat_o & ERR_FLAG_MASK);

endmodule

// File: rtl/tape_aux_regs.sv
module tape_aux_regs
  import tape_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          wr_count_i,
  input  logic          wr_addr_i,
  input  logic          wr_dbuf_i,
  input  logic          rd_lines_i,
  input  logic [DW-1:0] count_wd_i,
  input  logic [DW-1:0] addr_wd_i,
  input  logic [7:0]    dbuf_wd_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] addr_o,
  output logic [7:0]    dbuf_o,
  output logic          lines_o
);

  logic [DW-1:0] count_q, count_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [7:0]    dbuf_q, dbuf_d;
  logic          lines_q, lines_d;
  logic          count_en, addr_en, dbuf_en, lines_en;

  assign count_en = init_i | wr_count_i;
  assign addr_en  = init_i | wr_addr_i;
  assign dbuf_en  = init_i | wr_dbuf_i;
  assign lines_en = init_i | rd_lines_i;

  always_comb begin
    count_d = init_i ? '0   : count_wd_i;
    addr_d  = init_i ? '0   : addr_wd_i;
    dbuf_d  = init_i ? '0   : dbuf_wd_i;
    lines_d = init_i ? 1'b0 : ~lines_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      addr_q  <= '0;
      dbuf_q  <= '0;
      lines_q <= 1'b0;
    end else begin
      if (count_en) count_q <= count_d;
      if (addr_en)  addr_q  <= addr_d;
      if (dbuf_en)  dbuf_q  <= dbuf_d;
      if (lines_en) lines_q <= lines_d;
    end
  end

  assign count_o = count_q;
  assign addr_o  = addr_q;
  assign dbuf_o  = dbuf_q;
  assign lines_o = lines_q;

endmodule

// File: rtl/tape_regfile.sv
module tape_regfile
  import tape_regs_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_req_i,
  input  logic                      bus_we_i,
  input  logic                      bus_byte_i,
  input  logic [3:0]                bus_addr_i,
  input  logic [15:0]               bus_wdata_i,
  output logic [15:0]               bus_rdata_o,
  input  logic [NUM_UNITS*7-1:0]    unit_stat_i,
  input  logic                      fin_i,
  input  logic [5:0]                fin_err_i,
  input  logic                      fin_ill_i,
  output logic                      start_o,
  output logic [2:0]                start_func_o,
  output logic [2:0]                start_unit_o,
  output logic [17:0]               xfer_addr_o,
  output logic [15:0]               xfer_count_o,
  output logic                      irq_o
);

  logic          rst_meta, rst_sync;
  logic [2:0]    sel;
  logic          odd, wr_any, rd_any;
  logic          wr_cmd, wr_count, wr_addr, wr_dbuf, rd_lines;
  logic [DW-1:0] cmd_q, cmd_view, stat_view, cmd_wd;
  logic [DW-1:0] count_q, addr_q, count_wd, addr_wd;
  logic [7:0]    dbuf_q;
  logic          lines_q, lines_now;
  logic          done, irq, init_p, go_p, refuse_p, err_live, fin_take;
  logic          dbuf_keep;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign sel      = bus_addr_i[3:1];
  assign odd      = bus_addr_i[0];
  assign wr_any   = bus_req_i & bus_we_i;
  assign rd_any   = bus_req_i & ~bus_we_i;
  assign wr_cmd   = wr_any & (sel == SEL_CMD);
  assign wr_count = wr_any & (sel == SEL_COUNT);
  assign wr_addr  = wr_any & (sel == SEL_ADDR);
  assign dbuf_keep = bus_byte_i & odd;
  assign wr_dbuf  = wr_any & (sel == SEL_DBUF) & ~dbuf_keep;
  assign rd_lines = rd_any & (sel == SEL_LINES);

  always_comb begin
    cmd_view        = cmd_q;
    cmd_view[C_DONE] = done;
    cmd_view[C_ERR]  = err_live;
  end

  assign cmd_wd   = lane_merge(cmd_view, bus_wdata_i, bus_byte_i, odd);
  assign count_wd = lane_merge(count_q, bus_wdata_i, bus_byte_i, odd);
  assign addr_wd  = lane_merge(addr_q, bus_wdata_i, bus_byte_i, odd);
  assign fin_take = fin_i & ~done;

  tape_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_i     (wr_cmd),
    .wdata_i  (cmd_wd),
    .err_i    (err_live),
    .fin_i    (fin_i),
    .cmd_o    (cmd_q),
    .done_o   (done),
    .irq_o    (irq),
    .start_o  (start_o),
    .init_o   (init_p),
    .go_o     (go_p),
    .refuse_o (refuse_p)
  );

  tape_status #(.NUM_UNITS(NUM_UNITS)) u_stat (
    .clk         (clk),
    .rst_n       (rst_sync),
    .clr_i       (init_p | go_p),
    .set_ill_i   (refuse_p | (fin_take & fin_ill_i)),
    .fin_i       (fin_take),
    .fin_err_i   (fin_err_i),
    .unit_sel_i  (cmd_q[C_UNIT +: UNIT_W]),
    .unit_stat_i (unit_stat_i),
    .stat_o      (stat_view),
    .err_o       (err_live)
  );

  tape_aux_regs u_aux (
    .clk        (clk),
    .rst_n      (rst_sync),
    .init_i     (init_p),
    .wr_count_i (wr_count),
    .wr_addr_i  (wr_addr),
    .wr_dbuf_i  (wr_dbuf),
    .rd_lines_i (rd_lines),
    .count_wd_i (count_wd),
    .addr_wd_i  (addr_wd),
    .dbuf_wd_i  (bus_wdata_i[7:0]),
    .count_o    (count_q),
    .addr_o     (addr_q),
    .dbuf_o     (dbuf_q),
    .lines_o    (lines_q)
  );

  assign lines_now = ~lines_q;

  always_comb begin
    unique case (sel)
      SEL_STAT:  bus_rdata_o = stat_view;
      SEL_CMD:   bus_rdata_o = cmd_view;
      SEL_COUNT: bus_rdata_o = count_q;
      SEL_ADDR:  bus_rdata_o = addr_q;
      SEL_DBUF:  bus_rdata_o = {8'h00, dbuf_q};
      SEL_LINES: bus_rdata_o = {lines_now, 15'h0000};
      default:   bus_rdata_o = '0;
    endcase
  end

  assign start_func_o = cmd_q[C_FN +: 3];
  assign start_unit_o = cmd_q[C_UNIT +: UNIT_W];
  assign xfer_addr_o  = {cmd_q[C_EA +: 2], addr_q};
  assign xfer_count_o = count_q;
  assign irq_o        = irq;

endmodule

// File: rtl/tape_regfile_chk.sv
module tape_regfile_chk
  import tape_regs_pkg::*;
(
  input logic          clk,
  input logic          rst_sync,
  input logic          start_o,
  input logic          done,
  input logic          irq,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] cmd_view,
  input logic [DW-1:0] stat_view,
  input logic [DW-1:0] cmd_wd,
  input logic          wr_cmd,
  input logic          rd_lines,
  input logic          lines_q
);

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    start_o |=> !start_o);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    start_o |-> !done);

  // R8
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    irq |-> cmd_q[C_IE]);

  // R6
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_cmd && !done) |=> ($stable(cmd_q) && stat_view[S_ILL]));

  // R7
  init_reset_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_cmd && done && cmd_wd[C_INIT]) |=> (done && !irq && cmd_q == '0));

  // R12
  err_live_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    cmd_view[C_ERR] == (|(stat_view & ERR_FLAG_MASK)));

  // R13
  lines_toggle_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    rd_lines |=> (lines_q != $past(lines_q)));

endmodule

bind tape_regfile tape_regfile_chk u_chk (
  .clk       (clk),
  .rst_sync  (rst_sync),
  .start_o   (start_o),
  .done      (done),
  .irq       (irq),
  .cmd_q     (cmd_q),
  .cmd_view  (cmd_view),
  .stat_view (stat_view),
  .cmd_wd    (cmd_wd),
  .wr_cmd    (wr_cmd),
  .rd_lines  (rd_lines),
  .lines_q   (lines_q)
);

// File: tb/tape_regfile_tb_top.sv
module tape_regfile_tb_top;

  localparam int NU = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [NU*7-1:0] unit_stat = '0;
  logic          fin = 1'b0, fin_ill = 1'b0;
  logic [5:0]    fin_err = '0;
  logic          start;
  logic [2:0]    start_func, start_unit;
  logic [17:0]   xfer_addr;
  logic [15:0]   xfer_count;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tape_regfile #(.NUM_UNITS(NU)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req),
    .bus_we_i     (bus_we),
    .bus_byte_i   (bus_byte),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .unit_stat_i  (unit_stat),
    .fin_i        (fin),
    .fin_err_i    (fin_err),
    .fin_ill_i    (fin_ill),
    .start_o      (start),
    .start_func_o (start_func),
    .start_unit_o (start_unit),
    .xfer_addr_o  (xfer_addr),
    .xfer_count_o (xfer_count),
    .irq_o        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_byte = b; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_byte = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic finish_fn(input logic [5:0] e, input logic il);
    @(negedge clk);
    fin = 1'b1; fin_err = e; fin_ill = il;
    @(negedge clk);
    fin = 1'b0; fin_err = '0; fin_ill = 1'b0;
  endtask

  task automatic set_unit(input int u, input logic [6:0] s);
    unit_stat[u*7 +: 7] = s;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd2, d);  chk("R1 cmd after reset", d, 16'h0080);
    rd(4'd4, d);  chk("R1 count after reset", d, 16'h0000);
    rd(4'd6, d);  chk("R1 addr after reset", d, 16'h0000);
    rd(4'd8, d);  chk("R1 dbuf after reset", d, 16'h0000);
    chk("R1 irq after reset", irq, 0);
    chk("R1 no start after reset", start, 0);
    rd(4'd12, d); chk("R2 unused offset reads 0", d, 16'h0000);
    rd(4'd0, d);  chk("R11 status idle units", d, 16'h0001);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    wr(4'd4, 16'h1234, 1'b0);
    wr(4'd4, 16'h00AB, 1'b1);
    rd(4'd4, d); chk("R3 even byte count", d, 16'h12AB);
    wr(4'd5, 16'h00CD, 1'b1);
    rd(4'd4, d); chk("R3 odd byte count", d, 16'hCDAB);
    chk("R3 count output", xfer_count, 16'hCDAB);
    wr(4'd6, 16'h8001, 1'b0);
    wr(4'd7, 16'h0077, 1'b1);
    rd(4'd6, d); chk("R3 odd byte addr", d, 16'h7701);
    wr(4'd8, 16'hFFA5, 1'b0);
    rd(4'd8, d); chk("R4 dbuf 8 bits", d, 16'h00A5);
    wr(4'd9, 16'h003C, 1'b1);
    rd(4'd8, d); chk("R4 dbuf odd byte ignored", d, 16'h00A5);
    wr(4'd8, 16'h005A, 1'b1);
    rd(4'd8, d); chk("R4 dbuf even byte", d, 16'h005A);
    wr(4'd0, 16'hFFFF, 1'b0);
    rd(4'd0, d); chk("R2 status write ignored", d, 16'h0001);
  endtask

  task automatic t_cmd_fields();
    logic [15:0] d;
    wr(4'd2, 16'hEFFE, 1'b0);
    rd(4'd2, d); chk("R5 writable mask", d, 16'h6FFE);
    chk("R8 IE rise raises irq", irq, 1);
    chk("R5 ext addr to xfer", xfer_addr[17:16], 2'b11);
    wr(4'd2, 16'h0000, 1'b0);
    chk("R8 IE clear drops irq", irq, 0);
    rd(4'd2, d); chk("R5 cleared fields", d, 16'h0080);
  endtask

  task automatic t_go();
    logic [15:0] d;
    set_unit(5, 7'b0001100);
    wr(4'd2, 16'h0507, 1'b0);
    chk("R9 start pulse", start, 1);
    chk("R9 start func", start_func, 3);
    chk("R9 start unit", start_unit, 5);
    @(posedge clk); #1;
    chk("R9 start one cycle", start, 0);
    rd(4'd2, d); chk("R9 done cleared", d, 16'h0506);
    wr(4'd2, 16'h0000, 1'b0);
    rd(4'd2, d); chk("R6 refused write, R12 err set", d, 16'h8506);
    finish_fn(6'b000001, 1'b0);
    rd(4'd2, d); chk("R10 finish sets done", d, 16'h8586);
    rd(4'd0, d); chk("R10 R11 status flags", d, 16'hA061);
    chk("R10 no irq with IE off", irq, 0);
  endtask

  task automatic t_go_ie();
    logic [15:0] d;
    wr(4'd2, 16'h0543, 1'b0);
    chk("R9 start with IE", start, 1);
    chk("R9 go drops irq", irq, 0);
    rd(4'd0, d); chk("R9 errors cleared by go", d, 16'h0061);
    finish_fn(6'b000000, 1'b0);
    chk("R10 finish irq with IE", irq, 1);
    rd(4'd2, d); chk("R10 cmd after finish", d, 16'h05C2);
    finish_fn(6'b100000, 1'b1);
    rd(4'd0, d); chk("R10 finish ignored when done", d, 16'h0061);
    wr(4'd2, 16'h0502, 1'b0);
    chk("R8 IE off drops irq", irq, 0);
  endtask

  task automatic t_dynamic();
    logic [15:0] d;
    set_unit(5, 7'b0001101);
    rd(4'd0, d); chk("R11 unit eof", d, 16'h4061);
    rd(4'd2, d); chk("R12 eof drives err", d, 16'h8582);
    set_unit(5, 7'b1001101);
    rd(4'd0, d); chk("R11 busy clears ready", d, 16'h4060);
    set_unit(5, 7'b0001100);
    set_unit(2, 7'b0110000);
    wr(4'd2, 16'h0200, 1'b0);
    rd(4'd0, d); chk("R11 unit select", d, 16'h0007);
    rd(4'd2, d); chk("R12 no err", d, 16'h0280);
  endtask

  task automatic t_lines();
    logic [15:0] d;
    rd(4'd10, d); chk("R13 first toggle", d, 16'h8000);
    rd(4'd10, d); chk("R13 second toggle", d, 16'h0000);
    rd(4'd10, d); chk("R13 third toggle", d, 16'h8000);
  endtask

  task automatic t_init();
    logic [15:0] d;
    wr(4'd2, 16'h0040, 1'b0);
    chk("R8 irq before init", irq, 1);
    wr(4'd4, 16'h5555, 1'b0);
    wr(4'd3, 16'h0010, 1'b1);
    chk("R7 init drops irq", irq, 0);
    rd(4'd2, d); chk("R7 cmd after init", d, 16'h0080);
    rd(4'd4, d); chk("R7 count after init", d, 16'h0000);
    rd(4'd10, d); chk("R7 lines after init", d, 16'h8000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_bytes();
    t_cmd_fields();
    t_go();
    t_go_ie();
    t_dynamic();
    t_lines();
    t_init();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule